// File: doc/BRIEF.md
# CAN Bus Driver Enable and Idle Gate

This block sits between a control register and the physical side of a CAN controller. A two-bit driver-enable field selects which of two transmit outputs leave the high-impedance state. The same field also switches the receive input comparator on and off. The block decodes that field into the output-enable lines at once, with no register in the path.

The block also decides when the protocol engine may join the bus. When the controller moves from fully disabled to any enabled driver set, it must first see the bus idle. Idle here means a run of `IDLE_BITS` consecutive recessive bits (11 by default), counted on the sample strobe from the bit timing logic. Until that run completes, `bus_ready` stays low and the engine neither sends nor receives. Frame handling is outside this block.

The gate is a three-state machine:

- `ST_OFF`: the field is 00 and the drivers are off.
- `ST_WAIT`: the block is counting recessive bits.
- `ST_READY`: the engine may take part on the bus.

It has these transitions:

- `ST_OFF` to `ST_WAIT` when the field becomes non-zero.
- `ST_WAIT` to `ST_READY` on the strobe that completes the run.
- `ST_WAIT` to `ST_OFF` when the field returns to 00.
- `ST_READY` to `ST_OFF` when the field returns to 00.

Top module: `can_bus_gate`

## Requirements
- R1: With `drv_en` = 00, `tx0_oe`, `tx1_oe`, `rx_cmp_en` and `bus_ready` are all 0 in the same cycle.
- R2: `drv_en` = 01 sets only `tx0_oe`. 10 sets only `tx1_oe`. 11 sets both. `rx_cmp_en` is 1 for any non-zero value. All of these follow `drv_en` in the same cycle.
- R3: After `drv_en` leaves 00, the next clock edge starts the idle count at zero. `bus_ready` stays 0 until 11 consecutive strobes with `smp_bit` = 1 (1 = recessive) have been counted. It rises in the cycle after the edge that takes the eleventh such strobe.
- R4: A strobe with `smp_bit` = 0 (dominant) before the run completes restarts the count from zero.
- R5: The count advances only on cycles with `smp_stb` = 1. On other cycles `smp_bit` has no effect, which is seen as an unchanged number of strobes still needed before `bus_ready` rises.
- R6: Changing `drv_en` between two non-zero values neither clears `bus_ready` nor restarts a count in progress.
- R7: When `drv_en` returns to 00, `bus_ready` drops in that same cycle. Any later re-enable requires a fresh full run of recessive bits.
- R8: After reset the gate is in `ST_OFF`, so a non-zero `drv_en` held through reset still needs a full idle run before `bus_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 2 | Driver enable field: bit 0 for output 0, bit 1 for output 1 |
| smp_stb | input | 1 | One-cycle pulse per bit time from the bit timing logic |
| smp_bit | input | 1 | Sampled bus level, 1 = recessive, valid with `smp_stb` |
| tx0_oe | output | 1 | Output enable for transmit output 0 |
| tx1_oe | output | 1 | Output enable for transmit output 1 |
| rx_cmp_en | output | 1 | Receive comparator enable |
| bus_ready | output | 1 | Engine may transmit and receive |

## Verification
Directed sequences come first. One gives an uninterrupted run of exactly ten and then eleven recessive strobes, which shows that the threshold sits exactly at eleven. Another puts a dominant bit at the tenth position, which tells a restart apart from a count that merely holds. Dominant levels placed on cycles without a strobe show that the count advances only on the strobe. A walk 01→10→11 after ready, and again in the middle of a wait, separates a re-enable from a change between enabled sets. A random phase then mixes strobe gaps, rare dominant bits and rare changes of the enable field. It compares every cycle's outputs with a cycle model in the bench, which catches off-by-one and ordering faults that the directed cases miss.

// File: rtl/can_gate_pkg.sv
package can_gate_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } gate_state_t;

    localparam int unsigned DEF_IDLE_BITS = 11;
endpackage

// File: rtl/cg_drv_decode.sv
module cg_drv_decode #(
    parameter int unsigned N_DRV = 2
) (
    input  logic [N_DRV-1:0] drv_en,
    output logic [N_DRV-1:0] drv_oe,
    output logic             cmp_en,
    output logic             any_en
);
    genvar g;
    generate
        for (g = 0; g < N_DRV; g++) begin : g_drv
            assign drv_oe[g] = drv_en[g];
        end
    endgenerate

    always_comb begin
        any_en = |drv_en;
        cmp_en = any_en;
    end
endmodule

// File: rtl/cg_idle_counter.sv
module cg_idle_counter #(
    parameter int unsigned IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic stb,
    input  logic rec,
    output logic run_done
);
    localparam int unsigned CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (stb) begin
            if (!rec)
                cnt <= '0;
            else if (cnt != LAST)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb run_done = !clear && stb && rec && (cnt == LAST);

    // R4
    dominant_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && stb && !rec) |=> (cnt == '0));

    // R5
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !stb) |=> $stable(cnt));
endmodule

// File: rtl/cg_gate_fsm.sv
module cg_gate_fsm
    import can_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_en,
    input  logic run_done,
    input  logic stb,
    input  logic rec,
    output logic cnt_clear,
    output logic bus_ready
);
    gate_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (any_en) state_nx = ST_WAIT;
            ST_WAIT:  begin
                if (!any_en)       state_nx = ST_OFF;
                else if (run_done) state_nx = ST_READY;
            end
            ST_READY: if (!any_en) state_nx = ST_OFF;
            default:  state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        cnt_clear = (state != ST_WAIT);
        bus_ready = (state == ST_READY) && any_en;
    end

    // R3
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> $past(stb && rec && state == ST_WAIT));

    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READY && any_en) |=> (state == ST_READY));

    // R7
    disable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> (state == ST_OFF));

    // R8
    enable_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && any_en) |=> (state == ST_WAIT && !bus_ready));
endmodule

// File: rtl/can_bus_gate.sv
module can_bus_gate #(
    parameter int unsigned IDLE_BITS = can_gate_pkg::DEF_IDLE_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] drv_en,
    input  logic       smp_stb,
    input  logic       smp_bit,
    output logic       tx0_oe,
    output logic       tx1_oe,
    output logic       rx_cmp_en,
    output logic       bus_ready
);
    logic [1:0] oe_w;
    logic       any_en;
    logic       cnt_clear;
    logic       run_done;

    cg_drv_decode #(.N_DRV(2)) u_dec (
        .drv_en (drv_en),
        .drv_oe (oe_w),
        .cmp_en (rx_cmp_en),
        .any_en (any_en)
    );

    cg_idle_counter #(.IDLE_BITS(IDLE_BITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .stb      (smp_stb),
        .rec      (smp_bit),
        .run_done (run_done)
    );

    cg_gate_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_en    (any_en),
        .run_done  (run_done),
        .stb       (smp_stb),
        .rec       (smp_bit),
        .cnt_clear (cnt_clear),
        .bus_ready (bus_ready)
    );

    assign tx0_oe = oe_w[0];
    assign tx1_oe = oe_w[1];

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en == 2'b00) |-> !bus_ready);
endmodule

// File: tb/can_bus_gate_test.sv
module can_bus_gate_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDLE = 11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] drv_en = 2'b00;
    logic       smp_stb = 1'b0;
    logic       smp_bit = 1'b1;
    logic       tx0_oe, tx1_oe, rx_cmp_en, bus_ready;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int m_state = 0;
    int m_cnt = 0;

    can_bus_gate uut (
        .clk(clk), .rst_n(rst_n), .drv_en(drv_en),
        .smp_stb(smp_stb), .smp_bit(smp_bit),
        .tx0_oe(tx0_oe), .tx1_oe(tx1_oe),
        .rx_cmp_en(rx_cmp_en), .bus_ready(bus_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] expect_out(input logic [1:0] en, input int st);
        logic rdy;
        rdy = (st == 2) && (en != 2'b00);
        return {en[0], en[1], (en != 2'b00), rdy};
    endfunction

    task automatic check(input string tag);
        logic [3:0] act, exp;
        act = {tx0_oe, tx1_oe, rx_cmp_en, bus_ready};
        exp = expect_out(drv_en, m_state);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {tx0,tx1,cmp,ready} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_state = 0; m_cnt = 0;
        end else begin
            case (m_state)
                0: if (drv_en != 0) begin m_state = 1; m_cnt = 0; end
                1: begin
                    if (drv_en == 0) m_state = 0;
                    else if (smp_stb) begin
                        if (!smp_bit) m_cnt = 0;
                        else if (m_cnt == IDLE - 1) m_state = 2;
                        else m_cnt++;
                    end
                end
                default: if (drv_en == 0) m_state = 0;
            endcase
        end
    endtask

    task automatic step(input logic [1:0] en, input logic stb, input logic b, input string tag);
        @(negedge clk);
        drv_en = en; smp_stb = stb; smp_bit = b;
        #1;
        check(tag);
        @(posedge clk);
        model_edge();
    endtask

    task automatic rec_bits(input logic [1:0] en, input int n, input string tag);
        for (int i = 0; i < n; i++) step(en, 1'b1, 1'b1, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_v;
        logic [1:0] ren;
        seed_v = $urandom(32'd1234);
        // R8: reset with drivers requested
        drv_en = 2'b11;
        repeat (3) @(posedge clk);
        model_edge();
        @(negedge clk); rst_n = 1'b1;
        #1; check("R8 reset");
        @(posedge clk); model_edge();
        step(2'b11, 1'b0, 1'b1, "R8 no ready after reset");
        rec_bits(2'b11, IDLE - 1, "R8");
        step(2'b11, 1'b1, 1'b1, "R8 11th bit");
        step(2'b11, 1'b0, 1'b1, "R3 ready after run");

        // R1 / R7: disable clears at once
        step(2'b00, 1'b0, 1'b1, "R1 off");
        step(2'b00, 1'b1, 1'b1, "R7 off");
        // R2 decode
        step(2'b01, 1'b0, 1'b1, "R2 tx0 only");
        step(2'b10, 1'b0, 1'b1, "R2 tx1 only");
        step(2'b11, 1'b0, 1'b1, "R2 both");
        // R3: ten bits are not enough, eleventh is
        rec_bits(2'b11, IDLE - 1, "R3 ten bits");
        step(2'b11, 1'b0, 1'b1, "R3 not ready at ten");
        step(2'b11, 1'b1, 1'b1, "R3 eleventh");
        step(2'b11, 1'b0, 1'b1, "R3 ready");
        // R6: switching between non-zero sets
        step(2'b01, 1'b0, 1'b0, "R6 to 01");
        step(2'b10, 1'b1, 1'b0, "R6 to 10");
        step(2'b11, 1'b0, 1'b1, "R6 to 11");
        // R7: re-enable needs fresh run
        step(2'b00, 1'b0, 1'b1, "R7 drop");
        step(2'b10, 1'b0, 1'b1, "R7 re-enable");
        rec_bits(2'b10, 5, "R7 partial");
        // R6: switch mid-wait keeps count
        step(2'b01, 1'b0, 1'b1, "R6 mid-wait switch");
        rec_bits(2'b01, IDLE - 6, "R6 mid-wait");
        step(2'b01, 1'b1, 1'b1, "R6 completes");
        step(2'b01, 1'b0, 1'b1, "R6 ready kept count");
        // R4: dominant at tenth position
        step(2'b00, 1'b0, 1'b1, "R4 off");
        step(2'b11, 1'b0, 1'b1, "R4 enable");
        rec_bits(2'b11, IDLE - 2, "R4 nine");
        step(2'b11, 1'b1, 1'b0, "R4 dominant");
        rec_bits(2'b11, IDLE - 1, "R4 restart");
        step(2'b11, 1'b0, 1'b1, "R4 still waiting");
        step(2'b11, 1'b1, 1'b1, "R4 full run");
        step(2'b11, 1'b0, 1'b1, "R4 ready");
        // R5: dominant level without strobe ignored
        step(2'b00, 1'b0, 1'b1, "R5 off");
        step(2'b01, 1'b0, 1'b1, "R5 enable");
        for (int i = 0; i < IDLE - 1; i++) begin
            step(2'b01, 1'b1, 1'b1, "R5 bit");
            step(2'b01, 1'b0, 1'b0, "R5 gap dominant");
        end
        step(2'b01, 1'b1, 1'b1, "R5 eleventh");
        step(2'b01, 1'b0, 1'b0, "R5 ready");

        // random phase
        ren = 2'b01;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 59) == 0) ren = 2'($urandom_range(0, 3));
            step(ren, ($urandom_range(0, 2) == 0), ($urandom_range(0, 19) != 0), "R3 random");
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule